// File: doc/BRIEF.md
# Write-only I2C target receiver

This block is an I2C target that accepts writes and nothing else. A fast system clock oversamples the bus clock and data lines. The block finds START and STOP conditions and shifts in bytes. It compares the first byte of each transfer with a fixed 7-bit address that has one bit set by a strap pin. Once that address is accepted, it acknowledges every byte that follows and hands each one to local logic as a one-cycle strobe.

The block reads SCL only and never stretches the clock. The only level it can put on SDA is the acknowledge pull-down; apart from that, its data output stays released. An address byte that asks for a read, or that carries the wrong strap bit, gets no acknowledge. The block then stays silent until the next START or STOP. It does not decode the bytes it receives; it passes them on.

Top module: `i2c_write_target`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) releases SDA and clears rx_valid, start_evt and stop_evt. After reset the block ignores bus traffic until a START.
- R2: SDA falling while SCL is high raises start_evt for exactly one cycle in any state. This includes a repeated START in the middle of a transfer, which restarts address reception.
- R3: SDA rising while SCL is high raises stop_evt for exactly one cycle in any state. It returns the block to idle with SDA released.
- R4: Bytes are sampled MSB first, one bit on each SCL high phase. An address byte whose bits [7:2] are 011100, whose bit 1 equals addr_sel and whose bit 0 (R/W) is 0 is acknowledged.
- R5: An address byte whose bit 1 differs from addr_sel, or whose upper bits differ, is not acknowledged. All bytes after it are neither acknowledged nor delivered until the next START or STOP.
- R6: An address byte with R/W (bit 0) = 1 is never acknowledged, and the bytes after it are ignored as in R5.
- R7: Each data byte after an accepted address raises rx_valid for exactly one cycle with the byte on rx_data[7:0]. The byte keeps its first-received bit in bit 7, and rx_valid coincides with the start of its acknowledge.
- R8: The acknowledge pull-down starts after the SCL falling edge that ends bit 8. It holds through the whole high phase of the ninth SCL pulse and is released after the falling edge that ends that pulse.
- R9: Any number of data bytes may follow one accepted address, and each is acknowledged and delivered.
- R10: sda_pull is low whenever SCL is high during bits 1 to 8 of any byte, whether or not the block is addressed.
- R11: Both strap levels work. addr_sel = 0 selects address byte 0x70 and addr_sel = 1 selects 0x72.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous reset, active high |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad (wired level) |
| addr_sel | input | 1 | Strap level that address bit 1 must match |
| sda_pull | output | 1 | 1 = pull SDA low, 0 = release (open-drain control) |
| rx_valid | output | 1 | One-cycle strobe for a received data byte |
| rx_data | output | 8 | Received data byte, valid with rx_valid |
| start_evt | output | 1 | One-cycle flag on START or repeated START |
| stop_evt | output | 1 | One-cycle flag on STOP |

## Verification
The hardest state to reach is the one after a rejected address byte. In that state a mistaken acknowledge shows only as a wrong SDA level during a later ninth pulse. The bench sweeps every one of the 256 address bytes under both strap levels. After each address it sends a data byte and checks, on the wired SDA line, both acknowledge slots against the match rule computed from the byte. Directed sequences then place a repeated START after a rejected read address and apply a reset in the middle of a byte. Both must leave the block in a state that the next traffic can reveal.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_DATA,
      ST_DATA_ACK,
      ST_SKIP
   } rx_state_t;
endpackage

// File: rtl/i2c_rx_sync.sv
module i2c_rx_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic din,
   output logic dout
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("i2c_rx_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (rst) chain[i] <= RST_VAL;
               else     chain[i] <= din;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (rst) chain[i] <= RST_VAL;
               else     chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/i2c_rx_linemon.sv
module i2c_rx_linemon (
   input  logic clk,
   input  logic rst,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic scl_p, sda_p;

   always_ff @(posedge clk) begin
      if (rst) begin
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_p <= scl_s;
         sda_p <= sda_s;
      end
   end

   always_comb begin
      scl_rise  = scl_s & ~scl_p;
      scl_fall  = ~scl_s & scl_p;
      start_det = scl_s & scl_p & sda_p & ~sda_s;
      stop_det  = scl_s & scl_p & ~sda_p & sda_s;
   end
endmodule

// File: rtl/i2c_rx_shift.sv
module i2c_rx_shift #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         clear,
   input  logic         shift_en,
   input  logic         bit_in,
   output logic [W-1:0] data,
   output logic         full
);
   localparam int CNT_W = $clog2(W + 1);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(W);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         data <= '0;
         cnt  <= '0;
      end else if (clear) begin
         cnt  <= '0;
      end else if (shift_en && cnt != CNT_MAX) begin
         data <= {data[W-2:0], bit_in};
         cnt  <= cnt + 1'b1;
      end
   end

   assign full = (cnt == CNT_MAX);
endmodule

// File: rtl/i2c_write_target.sv
module i2c_write_target
   import i2c_rx_pkg::*;
#(
   parameter int         SYNC_STAGES = 2,
   parameter logic [7:0] ADDR_BASE   = 8'b0111_0000,
   parameter int         SEL_POS     = 1
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       scl_in,
   input  logic       sda_in,
   input  logic       addr_sel,
   output logic       sda_pull,
   output logic       rx_valid,
   output logic [7:0] rx_data,
   output logic       start_evt,
   output logic       stop_evt
);
   localparam int BYTE_W = 8;

   generate
      if (SEL_POS < 1 || SEL_POS >= BYTE_W) begin : g_bad_sel
         $error("i2c_write_target: SEL_POS must lie in 1..7");
      end
   endgenerate

   logic scl_s, sda_s;
   logic scl_rise, scl_fall, start_det, stop_det;
   logic [BYTE_W-1:0] shreg;
   logic byte_full, shift_clear, shift_en, addr_ok;
   logic [BYTE_W-1:0] addr_want;
   rx_state_t state;

   i2c_rx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_scl (
      .clk(clk), .rst(rst), .din(scl_in), .dout(scl_s));
   i2c_rx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sda (
      .clk(clk), .rst(rst), .din(sda_in), .dout(sda_s));

   i2c_rx_linemon u_mon (
      .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det));

   always_comb begin
      shift_clear = start_det | (state == ST_ADDR_ACK) | (state == ST_DATA_ACK);
      shift_en    = scl_rise & ((state == ST_ADDR) | (state == ST_DATA));
   end

   i2c_rx_shift #(.W(BYTE_W)) u_shift (
      .clk(clk), .rst(rst), .clear(shift_clear), .shift_en(shift_en),
      .bit_in(sda_s), .data(shreg), .full(byte_full));

   always_comb begin
      addr_want          = ADDR_BASE;
      addr_want[SEL_POS] = addr_sel;
      addr_want[0]       = 1'b0;
      addr_ok            = (shreg == addr_want);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state     <= ST_IDLE;
         sda_pull  <= 1'b0;
         rx_valid  <= 1'b0;
         rx_data   <= '0;
         start_evt <= 1'b0;
         stop_evt  <= 1'b0;
      end else begin
         rx_valid  <= 1'b0;
         start_evt <= start_det;
         stop_evt  <= stop_det;
         if (start_det) begin
            state    <= ST_ADDR;
            sda_pull <= 1'b0;
         end else if (stop_det) begin
            state    <= ST_IDLE;
            sda_pull <= 1'b0;
         end else begin
            case (state)
               ST_ADDR: begin
                  if (scl_fall && byte_full) begin
                     if (addr_ok) begin
                        state    <= ST_ADDR_ACK;
                        sda_pull <= 1'b1;
                     end else begin
                        state    <= ST_SKIP;
                     end
                  end
               end
               ST_DATA: begin
                  if (scl_fall && byte_full) begin
                     state    <= ST_DATA_ACK;
                     sda_pull <= 1'b1;
                     rx_valid <= 1'b1;
                     rx_data  <= shreg;
                  end
               end
               ST_ADDR_ACK, ST_DATA_ACK: begin
                  if (scl_fall) begin
                     state    <= ST_DATA;
                     sda_pull <= 1'b0;
                  end
               end
               default: sda_pull <= 1'b0;
            endcase
         end
      end
   end
endmodule

// File: rtl/i2c_write_target_chk.sv
module i2c_write_target_chk (
   input logic clk,
   input logic rst,
   input logic scl_s,
   input logic sda_pull,
   input logic rx_valid,
   input logic start_evt,
   input logic stop_evt
);
   // R2 R3
   start_stop_excl_chk: assert property (@(posedge clk) disable iff (rst)
      !(start_evt && stop_evt));

   // R7
   valid_with_ack_chk: assert property (@(posedge clk) disable iff (rst)
      rx_valid |-> sda_pull);

   // R7
   valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      rx_valid |=> !rx_valid);

   // R8
   ack_begin_low_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(sda_pull) |-> !scl_s);

   // R8
   ack_end_low_chk: assert property (@(posedge clk) disable iff (rst)
      ($fell(sda_pull) && !$past(rst)) |-> !scl_s);

   // R2
   start_release_chk: assert property (@(posedge clk) disable iff (rst)
      start_evt |-> !sda_pull);

   // R3
   stop_release_chk: assert property (@(posedge clk) disable iff (rst)
      stop_evt |-> (!sda_pull && !rx_valid));

   // R2
   start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      start_evt |=> !start_evt);
endmodule

bind i2c_write_target i2c_write_target_chk u_chk (
   .clk(clk), .rst(rst), .scl_s(scl_s), .sda_pull(sda_pull),
   .rx_valid(rx_valid), .start_evt(start_evt), .stop_evt(stop_evt));

// File: tb/i2c_write_target_tb.sv
module i2c_write_target_tb;
   localparam int HALF = 5;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic rst, scl, msda, sel;
   logic sda_pull, rx_valid, start_evt, stop_evt;
   logic [7:0] rx_data;
   logic sda_line;
   assign sda_line = msda & ~sda_pull;

   int checks = 0, errors = 0;
   int rx_cnt = 0, start_cnt = 0, stop_cnt = 0;
   int exp_starts = 0, exp_stops = 0;
   logic [7:0] last_rx = '0;
   bit finished = 0;

   i2c_write_target u_dut (
      .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda_line), .addr_sel(sel),
      .sda_pull(sda_pull), .rx_valid(rx_valid), .rx_data(rx_data),
      .start_evt(start_evt), .stop_evt(stop_evt));

   always @(negedge clk) begin
      if (!rst) begin
         if (rx_valid) begin
            rx_cnt++;
            last_rx = rx_data;
         end
         if (start_evt) start_cnt++;
         if (stop_evt)  stop_cnt++;
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic send_bit(input bit b);
      tick(1);
      msda = b;
      tick(HALF - 1);
      scl = 1'b1;
      tick(HALF / 2);
      check(!sda_pull, "R10 no pull in data bit", int'(sda_pull), 0);
      tick(HALF - HALF / 2);
      scl = 1'b0;
   endtask

   task automatic send_byte(input logic [7:0] d, output bit ack);
      logic p1;
      for (int i = 7; i >= 0; i--) send_bit(d[i]);
      tick(1);
      msda = 1'b1;
      tick(HALF - 1);
      scl = 1'b1;
      tick(1);
      ack = !sda_line;
      p1  = sda_pull;
      tick(HALF - 2);
      check(sda_pull == p1, "R8 ack held over high phase", int'(sda_pull), int'(p1));
      tick(1);
      scl = 1'b0;
      tick(HALF);
      check(!sda_pull, "R8 ack released after ninth pulse", int'(sda_pull), 0);
   endtask

   task automatic do_start();
      tick(1);
      msda = 1'b1;
      tick(HALF);
      scl = 1'b1;
      tick(HALF);
      msda = 1'b0;
      tick(HALF);
      scl = 1'b0;
      tick(HALF);
      exp_starts++;
   endtask

   task automatic do_stop();
      msda = 1'b0;
      tick(HALF);
      scl = 1'b1;
      tick(HALF);
      msda = 1'b1;
      tick(HALF);
      exp_stops++;
   endtask

   task automatic report();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      repeat (195000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         report();
         $finish;
      end
   end

   initial begin
      bit ack, ack2, exp;
      int r0;
      logic [7:0] dat;
      rst = 1'b1; scl = 1'b1; msda = 1'b1; sel = 1'b0;
      tick(5);
      rst = 1'b0;
      tick(1);
      // R1 reset state
      check(!sda_pull && !rx_valid && !start_evt && !stop_evt, "R1 reset outputs",
            int'({sda_pull, rx_valid, start_evt, stop_evt}), 0);

      // R1: byte without START after reset is ignored
      scl = 1'b0;
      send_byte(8'h70, ack);
      check(!ack, "R1 idle ignores byte", int'(ack), 0);
      scl = 1'b1; msda = 1'b1;
      tick(HALF);

      // R4 R5 R6 R11: sweep every address under both strap levels
      for (int s = 0; s < 2; s++) begin
         for (int a = 0; a < 256; a++) begin
            sel = s[0];
            dat = 8'(a) ^ 8'h3C;
            exp = (a[7:2] == 6'b011100) && (a[1] == s[0]) && !a[0];
            do_start();
            send_byte(8'(a), ack);
            check(ack == exp, exp ? "R4 R11 address ack" : (a[0] ? "R6 read nack" : "R5 address nack"),
                  int'(ack), int'(exp));
            r0 = rx_cnt;
            send_byte(dat, ack2);
            check(ack2 == exp, "R5 data after address", int'(ack2), int'(exp));
            tick(1);
            check(rx_cnt - r0 == (exp ? 1 : 0), "R7 delivery count", rx_cnt - r0, exp ? 1 : 0);
            if (exp) check(last_rx == dat, "R7 data value", int'(last_rx), int'(dat));
            do_stop();
            tick(3);
            check(start_cnt == exp_starts, "R2 start flag count", start_cnt, exp_starts);
            check(stop_cnt == exp_stops, "R3 stop flag count", stop_cnt, exp_stops);
         end
      end

      // R9: long write with strap 1
      sel = 1'b1;
      do_start();
      send_byte(8'h72, ack);
      check(ack, "R11 strap 1 address", int'(ack), 1);
      for (int k = 0; k < 6; k++) begin
         dat = 8'(k * 47 + 1) ^ 8'h80;
         r0 = rx_cnt;
         send_byte(dat, ack);
         tick(1);
         check(ack, "R9 every byte acked", int'(ack), 1);
         check(rx_cnt == r0 + 1 && last_rx == dat, "R9 byte delivered", int'(last_rx), int'(dat));
      end

      // R2 R6: repeated START to a read address, then back to a write
      do_start();
      send_byte(8'h73, ack);
      check(!ack, "R6 read after repeated start", int'(ack), 0);
      r0 = rx_cnt;
      send_byte(8'hA5, ack);
      tick(1);
      check(!ack && rx_cnt == r0, "R6 ignored after read", rx_cnt - r0, 0);
      do_start();
      send_byte(8'h72, ack);
      check(ack, "R2 repeated start readdresses", int'(ack), 1);
      send_byte(8'h5A, ack);
      tick(1);
      check(ack && last_rx == 8'h5A, "R2 data after repeated start", int'(last_rx), 8'h5A);
      do_stop();
      tick(3);
      check(start_cnt == exp_starts && stop_cnt == exp_stops, "R2 R3 event counts",
            start_cnt, exp_starts);

      // R3: after STOP, bytes without START are ignored
      scl = 1'b0;
      tick(HALF);
      send_byte(8'h72, ack);
      check(!ack, "R3 idle after stop", int'(ack), 0);
      scl = 1'b1; msda = 1'b1;
      tick(HALF);

      // R1: reset during an addressed write
      do_start();
      send_byte(8'h72, ack);
      rst = 1'b1;
      tick(2);
      rst = 1'b0;
      tick(1);
      check(!sda_pull && !rx_valid, "R1 reset mid transfer", int'(sda_pull), 0);
      r0 = rx_cnt;
      send_byte(8'h11, ack);
      tick(1);
      check(!ack && rx_cnt == r0, "R1 idle after reset", int'(ack), 0);

      finished = 1;
      report();
      $finish;
   end
endmodule